// File: doc/BRIEF.md
# Inverter Gate Interlock and Fault Logic

This block is the input-side protection logic of a three-phase inverter bridge with a brake switch. It receives seven active-low switch commands: one upper and one lower per phase, plus the brake. It turns them into seven active-high gate enables. On the way, it removes any command that would turn both switches of one phase on at once (shoot-through). It also removes the command to any bridge switch whose short-circuit sense has fired.

Faults are reported on three active-low, open-drain-style outputs:

- The protection fault output reports a latched phase interlock or a short-circuit trip.
- The supply fault output follows the lower-side control supply flag.
- The temperature fault output follows the over-temperature flag.

An active-low current-limit warning is set by the over-current comparator flag. It clears pulse by pulse on the next command edge. Every pin is a plain level signal: the block has no streaming data path, so it has no valid/ready handshake.

Commands are sampled once into a register stage. That stage is the only source of edges for the clear rules. A "switch-on edge" below means a high-to-low transition of a command pin, seen one cycle after it is captured.

Top module: `inv_gate_guard`

## Requirements
- R1: With no fault active, a LOW command pin gives a 1 on the matching gate output from the first rising clock edge that samples it. A HIGH pin gives 0. This holds for the upper outputs `gate_hi_o`, the lower outputs `gate_lo_o` and the brake output `gate_brk_o`. Bit p of each bus is phase p.
- R2: While the sampled upper and lower commands of a phase are both ON, both gates of that phase are 0. If the overlap lasts fewer than `GLITCH_CYCLES` sampled cycles, no fault is latched and `flt_prot_n_o` stays 1.
- R3: An overlap of `GLITCH_CYCLES` or more sampled cycles latches that phase's interlock. The latch drives `flt_prot_n_o` to 0 and holds both gates of that phase at 0, even when only one of the two commands remains ON.
- R4: A latched interlock clears only after each of its two command pins has made a fresh switch-on edge since the latch. It clears on the later of the two edges, and a single edge leaves it latched.
- R5: The brake command takes no part in the interlock. Holding the brake ON together with any bridge command trips nothing, and the brake gate follows its pin.
- R6: A 1 on one bridge switch's short-circuit sense bit latches a trip on that switch only. The trip forces that one gate to 0 and `flt_prot_n_o` to 0. It clears on the next switch-on edge of that switch's pin. A sense bit still at 1 keeps the trip set.
- R7: A 1 on `ovc_i` drives `warn_ilim_n_o` to 0 from the next clock edge. The warning returns to 1 after the next switch-on edge on any of the seven command pins, unless `ovc_i` is still 1.
- R8: `flt_supply_n_o` is the inverse of `supply_bad_i`, and `flt_temp_n_o` is the inverse of `overtemp_i`. Both follow their flags without a clock.
- R9: During and after reset, with all command pins HIGH, every gate output is 0 and every fault and warning output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hi_n_i | input | PHASES | Upper-switch commands, LOW = ON |
| cmd_lo_n_i | input | PHASES | Lower-switch commands, LOW = ON |
| cmd_brk_n_i | input | 1 | Brake-switch command, LOW = ON |
| sc_hi_i | input | PHASES | Short-circuit sense of the upper switches |
| sc_lo_i | input | PHASES | Short-circuit sense of the lower switches |
| ovc_i | input | 1 | Arm over-current comparator flag |
| supply_bad_i | input | 1 | Lower-side control supply out of range |
| overtemp_i | input | 1 | Over-temperature flag |
| gate_hi_o | output | PHASES | Upper gate enables |
| gate_lo_o | output | PHASES | Lower gate enables |
| gate_brk_o | output | 1 | Brake gate enable |
| flt_prot_n_o | output | 1 | Interlock / short-circuit fault, active low |
| flt_supply_n_o | output | 1 | Supply fault, active low |
| flt_temp_n_o | output | 1 | Over-temperature fault, active low |
| warn_ilim_n_o | output | 1 | Current-limit warning, active low |

## Verification
The hardest state to reach from the ports is a latched interlock that has seen a fresh switch-on edge on only one of its two pins. Reaching it is the only way to show that a single edge does not clear the latch. The stimulus holds both pins of a phase LOW past the filter, then cycles the upper pin HIGH and LOW while the lower pin stays HIGH. Only then does it cycle the lower pin, and it checks the fault output before and after that second edge. A trip whose sense bit is still asserted on the clearing edge is reached the same way: the sense bit is held through a full off/on cycle of the command.

// File: rtl/igg_pkg.sv
package igg_pkg;
  // Number of bridge phases; the brake is one extra switch outside the bridge.
  localparam int unsigned IGG_PHASES = 3;

  // Width of a counter that can hold 0..max.
  function automatic int unsigned cnt_width(input int unsigned max);
    return (max < 2) ? 1 : $clog2(max + 1);
  endfunction
endpackage

// File: rtl/igg_cmd_sampler.sv
module igg_cmd_sampler #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cmd_n_i,
  output logic [N-1:0] on_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] on_q, prev_q;

  // One register stage converts active-low pins to ON flags; a second copy
  // one cycle older gives the switch-on edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      prev_q <= '0;
    end else begin
      on_q   <= ~cmd_n_i;
      prev_q <= on_q;
    end
  end

  assign on_o   = on_q;
  assign rise_o = on_q & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R4
endmodule

// File: rtl/igg_trip_latch.sv
module igg_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  // Set dominates clear, so a condition still present keeps the trip.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  assign q_o = q;

  AST_TRIP_SETS:  assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R6
  AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && clr_i && !set_i) |=> !q_o); // R6
  AST_TRIP_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o); // R7
endmodule

// File: rtl/igg_phase_lock.sv
module igg_phase_lock #(
  parameter int unsigned GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_on_i,
  input  logic lo_on_i,
  input  logic hi_rise_i,
  input  logic lo_rise_i,
  output logic both_o,
  output logic lock_o
);
  localparam int unsigned CW = igg_pkg::cnt_width(GLITCH_CYCLES);
  localparam logic [CW-1:0] TRIP_AT = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lock_q, seen_hi_q, seen_lo_q;
  logic          got_hi, got_lo;

  assign both_o = hi_on_i & lo_on_i;
  assign got_hi = seen_hi_q | hi_rise_i;
  assign got_lo = seen_lo_q | lo_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lock_q    <= 1'b0;
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
    end else if (lock_q) begin
      // Latched: wait for a fresh switch-on edge on both pins.
      cnt_q <= '0;
      if (got_hi && got_lo) begin
        lock_q    <= 1'b0;
        seen_hi_q <= 1'b0;
        seen_lo_q <= 1'b0;
      end else begin
        seen_hi_q <= got_hi;
        seen_lo_q <= got_lo;
      end
    end else if (both_o) begin
      if (cnt_q == TRIP_AT) begin
        lock_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_NEEDS_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(both_o)); // R3
  AST_NO_LOCK_WITHOUT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && !both_o) |=> !lock_o); // R2
  AST_SINGLE_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !hi_rise_i && !lo_rise_i) |=> lock_o); // R4
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard #(
  parameter int unsigned PHASES        = igg_pkg::IGG_PHASES,
  parameter int unsigned GLITCH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] cmd_hi_n_i,
  input  logic [PHASES-1:0] cmd_lo_n_i,
  input  logic              cmd_brk_n_i,
  input  logic [PHASES-1:0] sc_hi_i,
  input  logic [PHASES-1:0] sc_lo_i,
  input  logic              ovc_i,
  input  logic              supply_bad_i,
  input  logic              overtemp_i,
  output logic [PHASES-1:0] gate_hi_o,
  output logic [PHASES-1:0] gate_lo_o,
  output logic              gate_brk_o,
  output logic              flt_prot_n_o,
  output logic              flt_supply_n_o,
  output logic              flt_temp_n_o,
  output logic              warn_ilim_n_o
);
  localparam int unsigned NCMD = 2 * PHASES + 1;
  localparam int unsigned BRK  = 2 * PHASES;

  logic [NCMD-1:0]   on, rise;
  logic [PHASES-1:0] both, lock, trip_hi, trip_lo;
  logic              warn_q;

  // Command bit order: upper phases, then lower phases, then brake.
  igg_cmd_sampler #(.N(NCMD)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_n_i ({cmd_brk_n_i, cmd_lo_n_i, cmd_hi_n_i}),
    .on_o    (on),
    .rise_o  (rise)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    igg_phase_lock #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .hi_on_i   (on[p]),
      .lo_on_i   (on[PHASES + p]),
      .hi_rise_i (rise[p]),
      .lo_rise_i (rise[PHASES + p]),
      .both_o    (both[p]),
      .lock_o    (lock[p])
    );

    igg_trip_latch u_sc_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sc_hi_i[p]),
      .clr_i (rise[p]),
      .q_o   (trip_hi[p])
    );

    igg_trip_latch u_sc_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sc_lo_i[p]),
      .clr_i (rise[PHASES + p]),
      .q_o   (trip_lo[p])
    );

    assign gate_hi_o[p] = on[p]          & ~both[p] & ~lock[p] & ~trip_hi[p];
    assign gate_lo_o[p] = on[PHASES + p] & ~both[p] & ~lock[p] & ~trip_lo[p];
  end

  // Brake: no interlock and no short-circuit shutdown.
  assign gate_brk_o = on[BRK];

  // Current-limit warning, cleared by any command's switch-on edge.
  igg_trip_latch u_warn (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ovc_i),
    .clr_i (|rise),
    .q_o   (warn_q)
  );

  assign flt_prot_n_o   = ~(|lock | |trip_hi | |trip_lo);
  assign flt_supply_n_o = ~supply_bad_i;
  assign flt_temp_n_o   = ~overtemp_i;
  assign warn_ilim_n_o  = ~warn_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi_o & gate_lo_o) == '0)); // R2
  AST_LOCK_FLAGS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != '0) |-> !flt_prot_n_o); // R3
  AST_LOCK_BLOCKS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi_o & lock) == '0) && ((gate_lo_o & lock) == '0)); // R3
  AST_SC_FLAGS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ((sc_hi_i | sc_lo_i) != '0) |=> !flt_prot_n_o); // R6
  AST_OVC_WARNS: assert property (@(posedge clk) disable iff (!rst_n)
    ovc_i |=> !warn_ilim_n_o); // R7
  AST_BRAKE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (gate_brk_o == !$past(cmd_brk_n_i))); // R5
endmodule

// File: tb/inv_gate_guard_tb.sv
module inv_gate_guard_tb;
  localparam int P = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] cmd_hi_n = '1, cmd_lo_n = '1, sc_hi = '0, sc_lo = '0;
  logic         cmd_brk_n = 1'b1, ovc = 1'b0, supply_bad = 1'b0, overtemp = 1'b0;
  logic [P-1:0] gate_hi, gate_lo;
  logic         gate_brk, flt_prot_n, flt_supply_n, flt_temp_n, warn_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  inv_gate_guard #(.PHASES(P), .GLITCH_CYCLES(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_hi_n_i(cmd_hi_n), .cmd_lo_n_i(cmd_lo_n), .cmd_brk_n_i(cmd_brk_n),
    .sc_hi_i(sc_hi), .sc_lo_i(sc_lo), .ovc_i(ovc),
    .supply_bad_i(supply_bad), .overtemp_i(overtemp),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .gate_brk_o(gate_brk),
    .flt_prot_n_o(flt_prot_n), .flt_supply_n_o(flt_supply_n),
    .flt_temp_n_o(flt_temp_n), .warn_ilim_n_o(warn_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance one clock; outputs are sampled 2 ns after the edge.
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic idle();
    cmd_hi_n = '1; cmd_lo_n = '1; cmd_brk_n = 1'b1;
    sc_hi = '0; sc_lo = '0; ovc = 1'b0;
    tick(3);
  endtask

  task automatic t_reset();
    chk("R9 gate_hi", 32'(gate_hi), 0);
    chk("R9 gate_lo", 32'(gate_lo), 0);
    chk("R9 gate_brk", 32'(gate_brk), 0);
    chk("R9 faults", 32'({flt_prot_n, flt_supply_n, flt_temp_n, warn_n}), 32'hF);
  endtask

  task automatic t_follow();
    cmd_hi_n = 3'b110; cmd_lo_n = 3'b101;
    tick();
    chk("R1 gate_hi", 32'(gate_hi), 32'b001);
    chk("R1 gate_lo", 32'(gate_lo), 32'b010);
    cmd_hi_n = 3'b011; cmd_lo_n = 3'b111;
    tick();
    chk("R1 gate_hi swap", 32'(gate_hi), 32'b100);
    chk("R1 gate_lo off", 32'(gate_lo), 0);
    idle();
  endtask

  task automatic t_short_overlap();
    cmd_hi_n = 3'b101; cmd_lo_n = 3'b101;
    tick();
    chk("R2 overlap gates off", 32'({gate_hi[1], gate_lo[1]}), 0);
    tick();
    cmd_hi_n = 3'b111; cmd_lo_n = 3'b111;
    tick(3);
    chk("R2 short overlap no fault", 32'(flt_prot_n), 1);
    idle();
  endtask

  task automatic t_lock_and_clear();
    cmd_hi_n = 3'b011; cmd_lo_n = 3'b011;
    tick(8);
    chk("R3 lock fault", 32'(flt_prot_n), 0);
    chk("R3 lock gates off", 32'({gate_hi[2], gate_lo[2]}), 0);
    cmd_lo_n = 3'b111;                      // only upper still ON
    tick(2);
    chk("R3 lock blocks single", 32'(gate_hi[2]), 0);
    cmd_hi_n = 3'b111; tick(2);
    cmd_hi_n = 3'b011; tick(3);             // fresh upper edge only
    chk("R4 single edge keeps lock", 32'(flt_prot_n), 0);
    cmd_hi_n = 3'b111; tick(2);
    cmd_lo_n = 3'b011; tick(2);             // later lower edge
    chk("R4 later edge clears", 32'(flt_prot_n), 1);
    chk("R4 lower gate back", 32'(gate_lo[2]), 1);
    idle();
  endtask

  task automatic t_brake();
    cmd_brk_n = 1'b0; cmd_lo_n = 3'b110; cmd_hi_n = 3'b101;
    tick(8);
    chk("R5 brake gate", 32'(gate_brk), 1);
    chk("R5 no trip", 32'(flt_prot_n), 1);
    chk("R5 bridge gates", 32'({gate_hi, gate_lo}), 32'b010_001);
    idle();
  endtask

  task automatic t_short_circuit();
    cmd_hi_n = 3'b110; cmd_lo_n = 3'b101;
    tick();
    sc_hi = 3'b001;
    tick();
    chk("R6 tripped gate off", 32'(gate_hi[0]), 0);
    chk("R6 other gate on", 32'(gate_lo[1]), 1);
    chk("R6 fault", 32'(flt_prot_n), 0);
    cmd_hi_n = 3'b111; tick(2);
    cmd_hi_n = 3'b110; tick(3);             // edge while sense still high
    chk("R6 set dominates", 32'(gate_hi[0]), 0);
    sc_hi = '0; tick(2);
    chk("R6 held without edge", 32'(flt_prot_n), 0);
    cmd_hi_n = 3'b111; tick(2);
    cmd_hi_n = 3'b110; tick(2);
    chk("R6 cleared on next pulse", 32'({flt_prot_n, gate_hi[0]}), 32'b11);
    idle();
  endtask

  task automatic t_warn();
    ovc = 1'b1; tick();
    chk("R7 warn set", 32'(warn_n), 0);
    ovc = 1'b0; tick(3);
    chk("R7 warn held", 32'(warn_n), 0);
    cmd_brk_n = 1'b0; tick(2);
    chk("R7 warn cleared by edge", 32'(warn_n), 1);
    idle();
  endtask

  task automatic t_supply_temp();
    supply_bad = 1'b1; #1;
    chk("R8 supply fault", 32'({flt_supply_n, flt_temp_n}), 32'b01);
    supply_bad = 1'b0; overtemp = 1'b1; #1;
    chk("R8 temp fault", 32'({flt_supply_n, flt_temp_n}), 32'b10);
    overtemp = 1'b0; #1;
    chk("R8 both idle", 32'({flt_supply_n, flt_temp_n}), 32'b11);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_follow();
    t_short_overlap();
    t_lock_and_clear();
    t_brake();
    t_short_circuit();
    t_warn();
    t_supply_temp();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule